// File: doc/BRIEF.md
# NAND Erase and Copy-Back Command Responder

This block is the device side of a NAND flash bus, cut down to what a host sequencer needs for block erase, page load and copy-back program. It watches the command-latch, address-latch and write-strobe pins. On each rising edge of the write strobe it takes one byte from the I/O bus as a command, an address or a data byte. An operation starts only when its whole pattern has arrived: the setup command, the right number of address cycles and the confirm command. While an operation runs, the block pulls the ready/busy line low for a number of clock cycles set by a parameter. It answers status and data reads on the read strobe.

The array is a small on-chip model: a page store, a blank flag for each page and one page buffer. Erase sets the blank flags of every page in a block. A page load copies a page into the buffer. Copy-back writes the buffer, after any patching by the host, to a target page. The block is meant to sit in a verification environment as a synthesizable partner for a host controller. Its busy times are parameters, so the host's wait and timeout logic can be exercised.

Address cycles for a page load and for copy-back come in this order: column low, column high, row low, row high. The row is `{rowHigh,rowLow}`. Its low `PAGE_BITS` bits select the page inside a block, and the next `BLOCK_BITS` bits select the block. Erase takes only the two row bytes.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset the ready/busy output is 1 and `ioOe` is 0 while the read strobe is high. A status read (command 70h, then a read-strobe low pulse) returns E0h.
- R2: Command 60h, then exactly two address cycles (row low, row high), then D0h starts an erase. The ready/busy line is low for exactly ERASE_CYCLES clock cycles, starting with the clock edge that samples the confirm strobe's rising edge. Afterwards every page of the addressed block reads as FFh, other blocks are unchanged, and status bit 0 is 0. The page-select bits of the row are ignored.
- R3: A D0h that comes after one or three address cycles, or without a preceding 60h, starts nothing. The ready/busy line stays 1 and the array is unchanged.
- R4: The status byte is {bit7=1, bit6=ready, bit5=ready, bits4..1=0, bit0=fail}. Ready is 0 while busy and 1 otherwise.
- R5: While busy, every command other than 70h and FFh is discarded, and so are address and data cycles. The running operation keeps its length and its effect.
- R6: 00h, four address cycles, then 35h load the addressed page into the buffer. A blank page loads as FFh. The ready/busy line is low for exactly READ_CYCLES cycles. After that, each read-strobe pulse returns one buffer byte, starting at the column address and advancing on the strobe's rising edge, wrapping within the page.
- R7: After a completed page load, 85h, four address cycles and 10h program the buffer into the target page. The ready/busy line is low for exactly PROG_CYCLES cycles, and status bit 0 is 0 when source and target row bit 0 are equal.
- R8: Data bytes written after the four 85h address cycles and before 10h overwrite the buffer from the column address upward, so only those bytes of the target page differ from the source page.
- R9: When the source and target row bit 0 differ, copy-back sets status bit 0 to 1 and leaves the target page unchanged.
- R10: 85h is ignored unless a page load has completed since the last reset. The 10h that follows then starts nothing and the target page is unchanged.
- R11: FFh, at any time including during busy, aborts the running operation without effect on the array. It holds ready/busy low for exactly RESET_CYCLES cycles, then status reads E0h, and the buffer must be loaded again before copy-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdLatchEn | input | 1 | Bus byte is a command when high |
| addrLatchEn | input | 1 | Bus byte is an address when high |
| wrEnN | input | 1 | Write strobe, active low, byte taken on its rising edge |
| rdEnN | input | 1 | Read strobe, active low, output advances on its rising edge |
| ioIn | input | 8 | Host-to-device bus byte |
| ioOut | output | 8 | Device-to-host byte (status or buffer data) |
| ioOe | output | 1 | High while the read strobe is low |
| rdyBsyN | output | 1 | Ready (1) or busy (0) |

## Verification
The write strobe's rising edge is seen at the first clock edge where the strobe is high after being low. Everything that byte starts happens at that edge. The bench therefore samples at the falling clock edge that follows, where ready/busy must already be 0. It then counts rising edges from that point and samples ready/busy one falling edge before and one falling edge after the edge at which the programmed duration runs out. Status and buffer bytes are driven combinationally from the state, so each is sampled one time unit after the read strobe falls, well away from any clock edge. A byte that should start nothing is judged a few cycles later by the ready/busy line, and afterwards by reading back the affected page.

// File: rtl/nfront_pkg.sv
package nfront_pkg;

  localparam logic [7:0] CMD_LOAD1   = 8'h00;
  localparam logic [7:0] CMD_LOAD2   = 8'h35;
  localparam logic [7:0] CMD_ERASE1  = 8'h60;
  localparam logic [7:0] CMD_ERASE2  = 8'hD0;
  localparam logic [7:0] CMD_CBPROG1 = 8'h85;
  localparam logic [7:0] CMD_CBPROG2 = 8'h10;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_RESET   = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ERASE, ST_LOAD, ST_CBACK, ST_BUSY
  } ctlState_t;

  typedef enum logic [1:0] {
    OP_ERASE, OP_LOAD, OP_PROG, OP_RST
  } opKind_t;

  typedef struct packed {
    logic       captAddr;
    logic [1:0] addrSlot;
    logic       captData;
    logic       doLoad;
    logic       doProg;
    logic       doErase;
    logic       doReset;
    logic       rdAdvance;
  } ctlStrobes_t;

endpackage

// File: rtl/nfront_ctrl.sv
module nfront_ctrl
  import nfront_pkg::*;
#(
  parameter int ERASE_CYCLES = 40,
  parameter int PROG_CYCLES  = 25,
  parameter int LOAD_CYCLES  = 10,
  parameter int RESET_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdLatchEn,
  input  logic        addrLatchEn,
  input  logic        wrEnN,
  input  logic        rdEnN,
  input  logic [7:0]  busIn,
  output ctlStrobes_t stb,
  output logic        busy,
  output logic        statusMode
);

  localparam int MAX_EP  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int MAX_LR  = (LOAD_CYCLES > RESET_CYCLES) ? LOAD_CYCLES : RESET_CYCLES;
  localparam int MAX_DUR = (MAX_EP > MAX_LR) ? MAX_EP : MAX_LR;
  localparam int CNT_W   = $clog2(MAX_DUR + 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] READ_LOAD  = CNT_W'(LOAD_CYCLES - 1);
  localparam logic [CNT_W-1:0] RST_LOAD   = CNT_W'(RESET_CYCLES - 1);

  logic weQ, reQ;
  logic weRise, reRise, cmdStb, addrStb, dataStb;

  ctlState_t        state, nxtState;
  opKind_t          opKind, nxtOp;
  logic [CNT_W-1:0] cycLeft, nxtCyc;
  logic [2:0]       addrCnt, nxtCnt, addrLimit;
  logic             bufLoaded, nxtLoaded, nxtMode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      weQ <= 1'b1;
      reQ <= 1'b1;
    end else begin
      weQ <= wrEnN;
      reQ <= rdEnN;
    end
  end

  assign weRise  = wrEnN & ~weQ;
  assign reRise  = rdEnN & ~reQ;
  assign cmdStb  = weRise & cmdLatchEn & ~addrLatchEn;
  assign addrStb = weRise & addrLatchEn & ~cmdLatchEn;
  assign dataStb = weRise & ~cmdLatchEn & ~addrLatchEn;
  assign busy    = (state == ST_BUSY);

  always_comb begin
    nxtState  = state;
    nxtOp     = opKind;
    nxtCyc    = cycLeft;
    nxtCnt    = addrCnt;
    nxtLoaded = bufLoaded;
    nxtMode   = statusMode;
    stb       = '0;
    addrLimit = (state == ST_ERASE) ? 3'd2 : 3'd4;

    if (state == ST_BUSY) begin
      if (cmdStb && busIn == CMD_RESET) begin
        nxtOp     = OP_RST;
        nxtCyc    = RST_LOAD;
        nxtLoaded = 1'b0;
      end else begin
        if (cmdStb && busIn == CMD_STATUS) nxtMode = 1'b1;
        if (cycLeft == '0) begin
          nxtState = ST_IDLE;
          unique case (opKind)
            OP_ERASE: stb.doErase = 1'b1;
            OP_LOAD: begin
              stb.doLoad = 1'b1;
              nxtLoaded  = 1'b1;
              nxtMode    = 1'b0;
            end
            OP_PROG:  stb.doProg = 1'b1;
            OP_RST: begin
              stb.doReset = 1'b1;
              nxtMode     = 1'b1;
            end
          endcase
        end else begin
          nxtCyc = cycLeft - 1'b1;
        end
      end
    end else begin
      if (cmdStb) begin
        nxtCnt = '0;
        case (busIn)
          CMD_RESET: begin
            nxtState  = ST_BUSY;
            nxtOp     = OP_RST;
            nxtCyc    = RST_LOAD;
            nxtLoaded = 1'b0;
          end
          CMD_STATUS: begin
            nxtMode = 1'b1;
            nxtCnt  = addrCnt;
          end
          CMD_ERASE1:  nxtState = ST_ERASE;
          CMD_LOAD1:   nxtState = ST_LOAD;
          CMD_CBPROG1: nxtState = bufLoaded ? ST_CBACK : ST_IDLE;
          CMD_ERASE2: begin
            if (state == ST_ERASE && addrCnt == 3'd2) begin
              nxtState = ST_BUSY;
              nxtOp    = OP_ERASE;
              nxtCyc   = ERASE_LOAD;
            end else nxtState = ST_IDLE;
          end
          CMD_LOAD2: begin
            if (state == ST_LOAD && addrCnt == 3'd4) begin
              nxtState = ST_BUSY;
              nxtOp    = OP_LOAD;
              nxtCyc   = READ_LOAD;
            end else nxtState = ST_IDLE;
          end
          CMD_CBPROG2: begin
            if (state == ST_CBACK && addrCnt == 3'd4) begin
              nxtState = ST_BUSY;
              nxtOp    = OP_PROG;
              nxtCyc   = PROG_LOAD;
            end else nxtState = ST_IDLE;
          end
          default: nxtState = ST_IDLE;
        endcase
      end else if (addrStb && state != ST_IDLE) begin
        if (addrCnt < addrLimit) begin
          stb.captAddr = 1'b1;
          stb.addrSlot = (state == ST_ERASE) ? addrCnt[1:0] + 2'd2 : addrCnt[1:0];
        end
        if (addrCnt != 3'd7) nxtCnt = addrCnt + 3'd1;
      end else if (dataStb && state == ST_CBACK && addrCnt == 3'd4) begin
        stb.captData = 1'b1;
      end
      if (reRise && !statusMode) stb.rdAdvance = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      opKind     <= OP_RST;
      cycLeft    <= '0;
      addrCnt    <= '0;
      bufLoaded  <= 1'b0;
      statusMode <= 1'b1;
    end else begin
      state      <= nxtState;
      opKind     <= nxtOp;
      cycLeft    <= nxtCyc;
      addrCnt    <= nxtCnt;
      bufLoaded  <= nxtLoaded;
      statusMode <= nxtMode;
    end
  end

  // R11: a reset byte always lands in a reset busy period
  a_r11_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStb && busIn == CMD_RESET) |=> (busy && opKind == OP_RST));

  // R5: other commands during busy neither end nor change the operation
  a_r5_busy_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cycLeft != '0 && cmdStb && busIn != CMD_RESET) |=> (busy && $stable(opKind)));

  // R3: an erase busy period only follows exactly two address cycles
  a_r3_erase_two_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && opKind == OP_ERASE) |-> ($past(addrCnt) == 3'd2 && $past(state) == ST_ERASE));

  // R7: array-changing commits only happen at the end of a busy period
  a_r7_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.doProg || stb.doErase || stb.doLoad) |-> busy);

endmodule

// File: rtl/nfront_dp.sv
module nfront_dp
  import nfront_pkg::*;
#(
  parameter int COL_BITS   = 3,
  parameter int PAGE_BITS  = 2,
  parameter int BLOCK_BITS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctlStrobes_t stb,
  input  logic [7:0]  busIn,
  input  logic        busy,
  input  logic        statusMode,
  output logic [7:0]  busOut
);

  localparam int PAGE_BYTES = 1 << COL_BITS;
  localparam int ROW_BITS   = PAGE_BITS + BLOCK_BITS;
  localparam int NUM_PAGES  = 1 << ROW_BITS;

  logic [7:0]          addrReg [4];
  logic [COL_BITS-1:0] colPtr;
  logic [7:0]          pageBuf [PAGE_BYTES];
  logic [7:0]          pageMem [NUM_PAGES][PAGE_BYTES];
  logic [NUM_PAGES-1:0] blank;
  logic                srcParity, failBit;

  logic [15:0]           rowAddr;
  logic [ROW_BITS-1:0]   tgtPage;
  logic [BLOCK_BITS-1:0] tgtBlock;
  logic                  parityOk;
  logic [7:0]            statusByte;

  assign rowAddr  = {addrReg[3], addrReg[2]};
  assign tgtPage  = rowAddr[ROW_BITS-1:0];
  assign tgtBlock = rowAddr[ROW_BITS-1:PAGE_BITS];
  assign parityOk = (srcParity == rowAddr[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) addrReg[i] <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= 8'hFF;
      colPtr    <= '0;
      srcParity <= 1'b0;
      failBit   <= 1'b0;
    end else begin
      if (stb.captAddr) begin
        addrReg[stb.addrSlot] <= busIn;
        if (stb.addrSlot == 2'd0) colPtr <= busIn[COL_BITS-1:0];
      end
      if (stb.captData) begin
        pageBuf[colPtr] <= busIn;
        colPtr          <= colPtr + 1'b1;
      end
      if (stb.rdAdvance) colPtr <= colPtr + 1'b1;
      if (stb.doLoad) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          pageBuf[i] <= blank[tgtPage] ? 8'hFF : pageMem[tgtPage][i];
        srcParity <= rowAddr[0];
      end
      if (stb.doProg)  failBit <= ~parityOk;
      if (stb.doErase) failBit <= 1'b0;
      if (stb.doReset) failBit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.doProg && parityOk)
      for (int i = 0; i < PAGE_BYTES; i++) pageMem[tgtPage][i] <= pageBuf[i];
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_blank
    localparam logic [BLOCK_BITS-1:0] MY_BLOCK = BLOCK_BITS'(p >> PAGE_BITS);
    always_ff @(posedge clk) begin
      if (!rst_n) blank[p] <= 1'b1;
      else if (stb.doErase && tgtBlock == MY_BLOCK) blank[p] <= 1'b1;
      else if (stb.doProg && parityOk && tgtPage == ROW_BITS'(p)) blank[p] <= 1'b0;
    end
  end

  assign statusByte = {1'b1, ~busy, ~busy, 4'b0000, failBit};
  assign busOut     = statusMode ? statusByte : pageBuf[colPtr];

  // R9: mismatched parity copy-back always reports fail
  a_r9_parity_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.doProg && !parityOk) |=> failBit);

  // R9: mismatched parity copy-back leaves the blank flags alone
  a_r9_target_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.doProg && !parityOk) |=> $stable(blank));

  // R2: a completed erase reports pass
  a_r2_erase_pass: assert property (@(posedge clk) disable iff (!rst_n)
    stb.doErase |=> !failBit);

  // R4: at most one commit per cycle
  a_r4_one_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.doLoad, stb.doProg, stb.doErase, stb.doReset}));

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nfront_pkg::*;
#(
  parameter int COL_BITS     = 3,
  parameter int PAGE_BITS    = 2,
  parameter int BLOCK_BITS   = 2,
  parameter int ERASE_CYCLES = 40,
  parameter int PROG_CYCLES  = 25,
  parameter int LOAD_CYCLES  = 10,
  parameter int RESET_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdLatchEn,
  input  logic       addrLatchEn,
  input  logic       wrEnN,
  input  logic       rdEnN,
  input  logic [7:0] ioIn,
  output logic [7:0] ioOut,
  output logic       ioOe,
  output logic       rdyBsyN
);

  ctlStrobes_t ctlStb;
  logic        busy, statusMode;

  nfront_ctrl #(
    .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES),
    .LOAD_CYCLES(LOAD_CYCLES), .RESET_CYCLES(RESET_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdLatchEn(cmdLatchEn), .addrLatchEn(addrLatchEn),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .busIn(ioIn),
    .stb(ctlStb), .busy(busy), .statusMode(statusMode)
  );

  nfront_dp #(
    .COL_BITS(COL_BITS), .PAGE_BITS(PAGE_BITS), .BLOCK_BITS(BLOCK_BITS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(ctlStb), .busIn(ioIn),
    .busy(busy), .statusMode(statusMode), .busOut(ioOut)
  );

  assign ioOe    = ~rdEnN;
  assign rdyBsyN = ~busy;

endmodule

// File: tb/sim_nand_cmd_front.sv
module sim_nand_cmd_front;

  localparam int CLK_PERIOD = 10;
  localparam int ERASE_N = 60;
  localparam int PROG_N  = 25;
  localparam int LOAD_N  = 8;
  localparam int RESET_N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cle = 1'b0, ale = 1'b0, weN = 1'b1, reN = 1'b1;
  logic [7:0] io = 8'h00;
  logic [7:0] ioOut;
  logic ioOe, rbN;

  int nChecks = 0;
  int nBad = 0;
  int ticks = 0;
  int t0 = 0;
  bit finished = 0;
  logic [7:0] model [16][8];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ticks <= ticks + 1;

  nand_cmd_front #(
    .ERASE_CYCLES(ERASE_N), .PROG_CYCLES(PROG_N),
    .LOAD_CYCLES(LOAD_N), .RESET_CYCLES(RESET_N)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmdLatchEn(cle), .addrLatchEn(ale),
    .wrEnN(weN), .rdEnN(reN), .ioIn(io),
    .ioOut(ioOut), .ioOe(ioOe), .rdyBsyN(rbN)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic weCycle(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk);
    cle = c; ale = a; io = d; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0;
    t0 = ticks;
  endtask

  task automatic cmd(input logic [7:0] d);  weCycle(1'b1, 1'b0, d); endtask
  task automatic adr(input logic [7:0] d);  weCycle(1'b0, 1'b1, d); endtask
  task automatic dat(input logic [7:0] d);  weCycle(1'b0, 1'b0, d); endtask

  task automatic reByte(output logic [7:0] v);
    @(negedge clk);
    reN = 1'b0;
    #1 v = ioOut;
    @(negedge clk);
    reN = 1'b1;
    @(negedge clk);
  endtask

  // busy started at the edge recorded in t0; low for n cycles exactly
  task automatic waitBusy(input string tag, input int n);
    check8({tag, " busy at start"}, {7'd0, rbN}, 8'd0);
    while (ticks < t0 + n - 1) @(negedge clk);
    check8({tag, " busy last cycle"}, {7'd0, rbN}, 8'd0);
    @(negedge clk);
    check8({tag, " ready after"}, {7'd0, rbN}, 8'd1);
  endtask

  task automatic noBusy(input string tag);
    repeat (3) @(negedge clk);
    check8({tag, " no busy"}, {7'd0, rbN}, 8'd1);
  endtask

  task automatic readStatus(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    cmd(8'h70);
    reByte(v);
    check8({tag, " status"}, v, exp);
  endtask

  task automatic loadPage(input int pg, input int col);
    cmd(8'h00); adr(8'(col)); adr(8'h00); adr(8'(pg)); adr(8'h00); cmd(8'h35);
    waitBusy("R6 load", LOAD_N);
  endtask

  task automatic checkPage(input string tag, input int pg, input int col);
    logic [7:0] v;
    loadPage(pg, col);
    for (int i = 0; i < 8; i++) begin
      reByte(v);
      check8($sformatf("%s page%0d byte%0d", tag, pg, (col + i) % 8), v, model[pg][(col + i) % 8]);
    end
  endtask

  task automatic t_reset;
    check8("R1 ready after reset", {7'd0, rbN}, 8'd1);
    check8("R1 oe idle", {7'd0, ioOe}, 8'd0);
    readStatus("R1", 8'hE0);
  endtask

  task automatic t_load_blank;
    checkPage("R6 blank", 2, 0);
  endtask

  task automatic t_cb_full;
    cmd(8'h85); adr(8'h00); adr(8'h00); adr(8'h02); adr(8'h00);
    for (int i = 0; i < 8; i++) dat(8'hA0 + 8'(i));
    cmd(8'h10);
    waitBusy("R7 prog", PROG_N);
    for (int i = 0; i < 8; i++) model[2][i] = 8'hA0 + 8'(i);
    readStatus("R7 R4 pass", 8'hE0);
    checkPage("R7 R8 full", 2, 0);
  endtask

  task automatic t_cb_partial;
    cmd(8'h85); adr(8'h03); adr(8'h00); adr(8'h04); adr(8'h00);
    dat(8'h55); dat(8'h66);
    cmd(8'h10);
    waitBusy("R8 prog", PROG_N);
    for (int i = 0; i < 8; i++) model[4][i] = model[2][i];
    model[4][3] = 8'h55;
    model[4][4] = 8'h66;
    checkPage("R8 patched", 4, 0);
    checkPage("R6 column start", 4, 5);
  endtask

  task automatic t_parity;
    cmd(8'h85); adr(8'h00); adr(8'h00); adr(8'h05); adr(8'h00);
    cmd(8'h10);
    waitBusy("R9 prog", PROG_N);
    readStatus("R9 fail", 8'hE1);
    checkPage("R9 target kept", 5, 0);
  endtask

  task automatic t_erase_bad;
    cmd(8'h60); adr(8'h00); cmd(8'hD0);
    noBusy("R3 one addr");
    cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
    noBusy("R3 three addr");
    cmd(8'hD0);
    noBusy("R3 lone confirm");
    checkPage("R3 intact", 2, 0);
  endtask

  task automatic t_erase;
    cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0);
    waitBusy("R2 erase", ERASE_N);
    for (int p = 0; p < 4; p++) for (int i = 0; i < 8; i++) model[p][i] = 8'hFF;
    readStatus("R2 pass", 8'hE0);
    checkPage("R2 erased", 2, 0);
    checkPage("R2 other block", 4, 0);
  endtask

  task automatic t_reset_abort;
    cmd(8'h60); adr(8'h04); adr(8'h00); cmd(8'hD0);
    repeat (5) @(negedge clk);
    check8("R11 erase running", {7'd0, rbN}, 8'd0);
    cmd(8'hFF);
    waitBusy("R11 reset", RESET_N);
    readStatus("R11", 8'hE0);
    checkPage("R11 aborted erase", 4, 0);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] v;
    int start;
    cmd(8'h60); adr(8'h04); adr(8'h00); cmd(8'hD0);
    start = t0;
    cmd(8'h70);
    reByte(v);
    check8("R4 R5 status busy", v, 8'h80);
    cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'h02); adr(8'h00); cmd(8'h35);
    cmd(8'h60); adr(8'h00); adr(8'h00); cmd(8'hD0);
    t0 = start;
    waitBusy("R5 erase length", ERASE_N);
    for (int p = 4; p < 8; p++) for (int i = 0; i < 8; i++) model[p][i] = 8'hFF;
    readStatus("R5 ready", 8'hE0);
    checkPage("R5 erased", 4, 0);
  endtask

  task automatic t_cb_unloaded;
    cmd(8'hFF);
    waitBusy("R10 reset", RESET_N);
    cmd(8'h85); adr(8'h00); adr(8'h00); adr(8'h06); adr(8'h00);
    dat(8'h12);
    cmd(8'h10);
    noBusy("R10 unloaded");
    checkPage("R10 target", 6, 0);
  endtask

  initial begin
    for (int p = 0; p < 16; p++) for (int i = 0; i < 8; i++) model[p][i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_blank();
    t_cb_full();
    t_cb_partial();
    t_parity();
    t_erase_bad();
    t_erase();
    t_reset_abort();
    t_busy_ignore();
    t_cb_unloaded();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nBad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule